// File: doc/BRIEF.md
# Three-Space DSP Word Memory

This block holds the data and program storage of a 24-bit fixed-point signal processor that addresses three separate spaces: two data spaces (X and Y) and a program space (P). Each space is addressed by a 16-bit word address, and every access moves one whole 24-bit word. One synchronous port takes a space code, an address, a write enable and write data. The word that the addressed location held before the access comes back one cycle later.

Every access is decoded to one of four kinds of storage. The first is a small private RAM per space. The second is a fixed constant table in X and Y, which is visible only while the ROM-enable input is high. The third is a 64-word peripheral window at the top of X and Y, which is forwarded to a side port. The fourth is a single shared external RAM. The external RAM is folded so that Y owns its lower half, X owns its upper half, and P sees both halves. All external addresses repeat every 32K words.

The external store holds 2^EXT_AW words. Its index is the top bit of the 15-bit folded address followed by the folded address's low EXT_AW-1 bits. With EXT_AW = 15 this is the full 32K-word store. Smaller values keep the X/Y/P fold and add more repetition inside each half.

Top module: `tri_space_mem`

## Requirements
- R1: After reset, `rvalid` and `rdata` are 0. Each cycle with `req` high is followed one cycle later by `rvalid` high. Each cycle with `req` low is followed by `rvalid` low, with `rdata` unchanged.
- R2: X and Y each own a private 256-word RAM at 0x0000–0x00FF. These RAMs are distinct from each other and from the external RAM.
- R3: P owns a private 512-word RAM at 0x0000–0x01FF.
- R4: When `rom_en` is 1, X and Y addresses 0x0100–0x01FF read a constant table, and writes there change nothing. With k = addr[7:0], X returns {8'hA5, k, ~k} and Y returns {8'h5A, ~k, k}.
- R5: When `rom_en` is 0, X and Y addresses 0x0100–0x01FF go to the external RAM under the R7 fold.
- R6: An X or Y access at 0xFFC0–0xFFFF does not touch any RAM. In the access cycle it raises `per_stb` and drives `per_off` = addr[5:0], `per_is_y` (1 for Y), `per_we` and `per_wdata`. The word on `per_rdata` in that cycle appears on `rdata` one cycle later.
- R7: The external fold uses a 15-bit address. For P it is addr[14:0]. For Y it is {0, addr[13:0]}, and for X it is {1, addr[13:0]}. Every P address from 0x0200 upward is external, including 0xFFC0–0xFFFF.
- R8: X addresses 0x0300, 0x4300, 0x8300 and 0xC300 and P addresses 0x4300 and 0xC300 all reach one external word. X 0x0000 and X 0x4000 are distinct words.
- R9: `rdata` always returns the content the location held before the access. A write therefore returns the old word.
- R10: Space code 2'b00 selects X and 2'b01 selects Y. Codes 2'b10 and 2'b11 both select P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request this cycle |
| space | input | 2 | Space code: 0 X, 1 Y, 2 or 3 P |
| addr | input | 16 | Word address |
| we | input | 1 | Write when 1, read when 0 |
| wdata | input | 24 | Write word |
| rom_en | input | 1 | Makes the X/Y constant tables visible |
| rdata | output | 24 | Prior content of the accessed word |
| rvalid | output | 1 | `rdata` belongs to the previous cycle's access |
| per_stb | output | 1 | Peripheral-window access strobe |
| per_off | output | 6 | Offset inside the window |
| per_is_y | output | 1 | Window access came from Y |
| per_we | output | 1 | Window access is a write |
| per_wdata | output | 24 | Window write word |
| per_rdata | input | 24 | Window read word from the peripheral side |

## Verification
The bound checker watches four things on every cycle: the one-cycle `rvalid` timing and the hold of `rdata` between accesses, the match between the window address range and `per_stb` with its side fields, the return of `per_rdata`, and the constant-table words whenever `rom_en` is high. Storage behaviour needs earlier writes to be visible, so only the bench scenarios can show it. Those scenarios cover the separation of the private RAMs, the fold and mirroring of external addresses, the fall-through of the table range when `rom_en` is low, and the fact that table writes and window accesses leave all RAM words untouched.

// File: rtl/dspmem_pkg.sv
package dspmem_pkg;

    localparam int WORD_W    = 24;
    localparam int ADDR_W    = 16;
    localparam int FOLD_W    = 15;
    localparam int XY_PRIV_W = 8;
    localparam int P_PRIV_W  = 9;
    localparam int WIN_W     = 6;

    typedef enum logic [1:0] {
        SP_X   = 2'b00,
        SP_Y   = 2'b01,
        SP_P   = 2'b10,
        SP_P_B = 2'b11
    } space_e;

    typedef enum logic [2:0] {
        TG_PRIV_X,
        TG_PRIV_Y,
        TG_PRIV_P,
        TG_TAB_X,
        TG_TAB_Y,
        TG_EXT,
        TG_WIN
    } target_e;

    typedef struct packed {
        target_e             tgt;
        logic [FOLD_W-1:0]   fold;
        logic [P_PRIV_W-1:0] idx;
    } route_t;

    function automatic logic [WORD_W-1:0] tab_word(input logic is_y, input logic [7:0] k);
        return is_y ? {8'h5A, ~k, k} : {8'hA5, k, ~k};
    endfunction

    function automatic logic is_data_space(input logic [1:0] sp);
        return !sp[1];
    endfunction

endpackage

// File: rtl/dspmem_decode.sv
module dspmem_decode
    import dspmem_pkg::*;
(
    input  logic [1:0]        space,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    output route_t            route
);

    logic data_sp;
    logic sel_y;
    logic low_priv_xy;
    logic low_priv_p;
    logic tab_range;
    logic win_range;

    always_comb begin
        data_sp     = is_data_space(space);
        sel_y       = (space == SP_Y);
        low_priv_xy = (addr[ADDR_W-1:XY_PRIV_W] == '0);
        low_priv_p  = (addr[ADDR_W-1:P_PRIV_W] == '0);
        tab_range   = (addr[ADDR_W-1:XY_PRIV_W] == 8'h01);
        win_range   = (addr[ADDR_W-1:WIN_W] == '1);

        route.idx  = addr[P_PRIV_W-1:0];
        route.fold = data_sp ? {~sel_y, addr[FOLD_W-2:0]} : addr[FOLD_W-1:0];

        if (data_sp) begin
            if (low_priv_xy)
                route.tgt = sel_y ? TG_PRIV_Y : TG_PRIV_X;
            else if (tab_range && rom_en)
                route.tgt = sel_y ? TG_TAB_Y : TG_TAB_X;
            else if (win_range)
                route.tgt = TG_WIN;
            else
                route.tgt = TG_EXT;
        end else begin
            route.tgt = low_priv_p ? TG_PRIV_P : TG_EXT;
        end
    end

endmodule

// File: rtl/dspmem_ram.sv
module dspmem_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            rdata <= mem[addr];
            if (we)
                mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/dspmem_tab.sv
module dspmem_tab
    import dspmem_pkg::*;
(
    input  logic              clk,
    input  logic              en,
    input  logic              is_y,
    input  logic [7:0]        k,
    output logic [WORD_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (en)
            rdata <= tab_word(is_y, k);
    end

endmodule

// File: rtl/tri_space_mem.sv
module tri_space_mem
    import dspmem_pkg::*;
#(
    parameter int EXT_AW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        space,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rom_en,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    output logic              per_stb,
    output logic [WIN_W-1:0]  per_off,
    output logic              per_is_y,
    output logic              per_we,
    output logic [WORD_W-1:0] per_wdata,
    input  logic [WORD_W-1:0] per_rdata
);

    localparam int EXT_LOW = EXT_AW - 1;

    route_t            route;
    target_e           tgt_q;
    logic [WORD_W-1:0] win_q;
    logic [WORD_W-1:0] priv_q [2];
    logic [WORD_W-1:0] privp_q;
    logic [WORD_W-1:0] tab_q;
    logic [WORD_W-1:0] ext_q;
    logic [EXT_AW-1:0] ext_idx;
    logic              tab_hit;

    dspmem_decode u_dec (
        .space  (space),
        .addr   (addr),
        .rom_en (rom_en),
        .route  (route)
    );

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_xy_priv
            localparam target_e MY_TGT = (g == 0) ? TG_PRIV_X : TG_PRIV_Y;
            dspmem_ram #(.AW(XY_PRIV_W), .DW(WORD_W)) u_ram (
                .clk   (clk),
                .en    (req && route.tgt == MY_TGT),
                .we    (we),
                .addr  (route.idx[XY_PRIV_W-1:0]),
                .wdata (wdata),
                .rdata (priv_q[g])
            );
        end
    endgenerate

    dspmem_ram #(.AW(P_PRIV_W), .DW(WORD_W)) u_p_priv (
        .clk   (clk),
        .en    (req && route.tgt == TG_PRIV_P),
        .we    (we),
        .addr  (route.idx),
        .wdata (wdata),
        .rdata (privp_q)
    );

    assign ext_idx = {route.fold[FOLD_W-1], route.fold[EXT_LOW-1:0]};

    dspmem_ram #(.AW(EXT_AW), .DW(WORD_W)) u_ext (
        .clk   (clk),
        .en    (req && route.tgt == TG_EXT),
        .we    (we),
        .addr  (ext_idx),
        .wdata (wdata),
        .rdata (ext_q)
    );

    assign tab_hit = (route.tgt == TG_TAB_X) || (route.tgt == TG_TAB_Y);

    dspmem_tab u_tab (
        .clk   (clk),
        .en    (req && tab_hit),
        .is_y  (route.tgt == TG_TAB_Y),
        .k     (route.idx[7:0]),
        .rdata (tab_q)
    );

    always_comb begin
        per_stb   = req && (route.tgt == TG_WIN);
        per_off   = addr[WIN_W-1:0];
        per_is_y  = (space == SP_Y);
        per_we    = we;
        per_wdata = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            tgt_q  <= TG_WIN;
            win_q  <= '0;
        end else begin
            rvalid <= req;
            if (req) begin
                tgt_q <= route.tgt;
                if (route.tgt == TG_WIN)
                    win_q <= per_rdata;
            end
        end
    end

    always_comb begin
        unique case (tgt_q)
            TG_PRIV_X: rdata = priv_q[0];
            TG_PRIV_Y: rdata = priv_q[1];
            TG_PRIV_P: rdata = privp_q;
            TG_TAB_X,
            TG_TAB_Y:  rdata = tab_q;
            TG_EXT:    rdata = ext_q;
            default:   rdata = win_q;
        endcase
    end

endmodule

// File: rtl/tri_space_mem_chk.sv
module tri_space_mem_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic [1:0]  space,
    input logic [15:0] addr,
    input logic        we,
    input logic [23:0] wdata,
    input logic        rom_en,
    input logic [23:0] rdata,
    input logic        rvalid,
    input logic        per_stb,
    input logic [5:0]  per_off,
    input logic        per_is_y,
    input logic        per_we,
    input logic [23:0] per_wdata,
    input logic [23:0] per_rdata
);

    logic win_in;
    logic tab_in;
    assign win_in = req && !space[1] && addr >= 16'hFFC0;
    assign tab_in = req && rom_en && !space[1] && addr >= 16'h0100 && addr <= 16'h01FF;

    a_r1_valid_after_access: assert property (@(posedge clk) disable iff (rst)
        req |=> rvalid);

    a_r1_no_valid_when_idle: assert property (@(posedge clk) disable iff (rst)
        !req |=> !rvalid);

    a_r1_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(rdata));

    a_r6_window_strobe: assert property (@(posedge clk) disable iff (rst)
        win_in |-> per_stb && per_off == addr[5:0] && per_is_y == space[0]
                   && per_we == we && per_wdata == wdata);

    a_r6_strobe_only_in_window: assert property (@(posedge clk) disable iff (rst)
        per_stb |-> win_in);

    a_r6_window_read_data: assert property (@(posedge clk) disable iff (rst)
        win_in |=> rdata == $past(per_rdata));

    a_r4_table_word: assert property (@(posedge clk) disable iff (rst)
        tab_in |=> rdata == ($past(space[0])
                             ? {8'h5A, ~$past(addr[7:0]), $past(addr[7:0])}
                             : {8'hA5, $past(addr[7:0]), ~$past(addr[7:0])}));

endmodule

bind tri_space_mem tri_space_mem_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .space     (space),
    .addr      (addr),
    .we        (we),
    .wdata     (wdata),
    .rom_en    (rom_en),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .per_stb   (per_stb),
    .per_off   (per_off),
    .per_is_y  (per_is_y),
    .per_we    (per_we),
    .per_wdata (per_wdata),
    .per_rdata (per_rdata)
);

// File: tb/test_tri_space_mem.sv
`timescale 1ns/1ps
module test_tri_space_mem;

    localparam int EA = 11;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [1:0]  space;
    logic [15:0] addr;
    logic        we;
    logic [23:0] wdata;
    logic        rom_en;
    logic [23:0] rdata;
    logic        rvalid;
    logic        per_stb;
    logic [5:0]  per_off;
    logic        per_is_y;
    logic        per_we;
    logic [23:0] per_wdata;
    logic [23:0] per_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [23:0] m_x [256];
    logic [23:0] m_y [256];
    logic [23:0] m_p [512];
    logic [23:0] m_e [1 << EA];

    always #4 clk = ~clk;

    tri_space_mem #(.EXT_AW(EA)) i_tri_space_mem (
        .clk(clk), .rst(rst), .req(req), .space(space), .addr(addr), .we(we),
        .wdata(wdata), .rom_en(rom_en), .rdata(rdata), .rvalid(rvalid),
        .per_stb(per_stb), .per_off(per_off), .per_is_y(per_is_y),
        .per_we(per_we), .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    task automatic check(input bit ok, input string rq, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // R7 fold: P uses addr[14:0]; X {1,addr[13:0]}; Y {0,addr[13:0]}; store index {f[14], f[EA-2:0]}
    function automatic int ext_index(input logic [1:0] sp, input logic [15:0] a);
        logic [14:0] f;
        f = sp[1] ? a[14:0] : {~sp[0], a[13:0]};
        return (int'(f[14]) << (EA - 1)) | (int'(f) & ((1 << (EA - 1)) - 1));
    endfunction

    // 0 priv-X, 1 priv-Y, 2 priv-P, 3 table, 4 window, 5 external (R2-R7, R10)
    function automatic int kind(input logic [1:0] sp, input logic [15:0] a, input logic ren);
        if (sp[1]) return (a < 16'h0200) ? 2 : 5;
        if (a < 16'h0100) return sp[0] ? 1 : 0;
        if (a < 16'h0200 && ren) return 3;
        if (a >= 16'hFFC0) return 4;
        return 5;
    endfunction

    task automatic acc(input logic [1:0] sp, input logic [15:0] a, input logic w,
                       input logic [23:0] d, input string rq);
        int k;
        logic [23:0] exp;
        k = kind(sp, a, rom_en);
        case (k)
            0: exp = m_x[a[7:0]];
            1: exp = m_y[a[7:0]];
            2: exp = m_p[a[8:0]];
            3: exp = sp[0] ? {8'h5A, ~a[7:0], a[7:0]} : {8'hA5, a[7:0], ~a[7:0]};
            4: exp = per_rdata;
            default: exp = m_e[ext_index(sp, a)];
        endcase
        @(negedge clk);
        req = 1'b1; space = sp; addr = a; we = w; wdata = d;
        #1;
        if (k == 4)
            check(per_stb && per_off == a[5:0] && per_is_y == sp[0] && per_we == w
                  && (!w || per_wdata == d), "R6 strobe", {per_stb, per_off, per_is_y, per_we}, {1'b1, a[5:0], sp[0], w});
        else
            check(!per_stb, "R6 no strobe", {23'd0, per_stb}, 24'd0);
        if (w) begin
            case (k)
                0: m_x[a[7:0]] = d;
                1: m_y[a[7:0]] = d;
                2: m_p[a[8:0]] = d;
                5: m_e[ext_index(sp, a)] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        req = 1'b0;
        check(rvalid === 1'b1 && rdata === exp, rq, rdata, exp);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 24'd0, 24'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = 1'b0; space = 2'b00; addr = '0; we = 1'b0;
        wdata = '0; rom_en = 1'b0; per_rdata = 24'h0C0FFE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rvalid === 1'b0 && rdata === 24'd0, "R1 reset", rdata, 24'd0);

        // fill private RAMs and the whole external store; first writes return X, so seed models
        for (int i = 0; i < 256; i++) begin m_x[i] = 'x; m_y[i] = 'x; end
        for (int i = 0; i < 512; i++) m_p[i] = 'x;
        for (int i = 0; i < (1 << EA); i++) m_e[i] = 'x;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); req = 1; space = 2'b00; addr = 16'(i); we = 1; wdata = 24'h100000 | 24'(i);
            @(negedge clk); space = 2'b01; wdata = 24'h200000 | 24'(i);
            m_x[i] = 24'h100000 | 24'(i); m_y[i] = 24'h200000 | 24'(i);
        end
        for (int i = 0; i < 512; i++) begin
            @(negedge clk); req = 1; space = 2'b10; addr = 16'(i); we = 1; wdata = 24'h300000 | 24'(i);
            m_p[i] = 24'h300000 | 24'(i);
        end
        for (int i = 0; i < (1 << (EA - 1)); i++) begin
            @(negedge clk); req = 1; space = 2'b10; addr = 16'h8000 | 16'(i); we = 1; wdata = 24'h400000 | 24'(i);
            m_e[i] = 24'h400000 | 24'(i);
            @(negedge clk); addr = 16'hC000 | 16'(i); wdata = 24'h500000 | 24'(i);
            m_e[(1 << (EA - 1)) + i] = 24'h500000 | 24'(i);
        end
        @(negedge clk); req = 0; we = 0;

        // sweeps with the table hidden (R2, R3, R5, R7, R10)
        for (int a = 0; a < 16'h1000; a++) begin
            acc(2'b00, 16'(a), 1'b0, 24'd0, (a < 256) ? "R2 X private" : "R5/R7 X external");
            acc(2'b01, 16'(a), 1'b0, 24'd0, (a < 256) ? "R2 Y private" : "R5/R7 Y external");
            acc(2'b10, 16'(a), 1'b0, 24'd0, (a < 512) ? "R3 P private" : "R7 P external");
        end
        for (int a = 0; a < 16'h0400; a++)
            acc(2'b11, 16'h7C00 | 16'(a), 1'b0, 24'd0, "R10 space code 3 is P");
        acc(2'b10, 16'hFFC3, 1'b0, 24'd0, "R7 P top is external");

        // tables visible (R4)
        rom_en = 1'b1;
        for (int a = 16'h00F0; a < 16'h0210; a++) begin
            acc(2'b00, 16'(a), 1'b0, 24'd0, "R4 X table");
            acc(2'b01, 16'(a), 1'b0, 24'd0, "R4 Y table");
        end
        acc(2'b00, 16'h0150, 1'b1, 24'h777777, "R4 table write");
        acc(2'b00, 16'h0150, 1'b0, 24'd0, "R4 table unchanged");
        acc(2'b01, 16'h01A0, 1'b1, 24'h666666, "R4 table write Y");
        rom_en = 1'b0;
        acc(2'b00, 16'h0150, 1'b0, 24'd0, "R4 external under table unchanged");
        acc(2'b01, 16'h01A0, 1'b0, 24'd0, "R4 external under Y table unchanged");

        // window (R6)
        acc(2'b00, 16'hFFC5, 1'b0, 24'd0, "R6 window read");
        per_rdata = 24'h5EED01;
        acc(2'b01, 16'hFFFF, 1'b1, 24'h123456, "R6 window write");
        acc(2'b00, 16'hFFC0, 1'b1, 24'hABCDEF, "R6 window write X");
        acc(2'b00, 16'h7FC5, 1'b0, 24'd0, "R6 fold target untouched");
        acc(2'b01, 16'h3FFF, 1'b0, 24'd0, "R6 fold target untouched Y");

        // aliases (R8) and old-data return on writes (R9)
        acc(2'b00, 16'h0300, 1'b1, 24'hABC123, "R9 write returns old");
        acc(2'b00, 16'h4300, 1'b0, 24'd0, "R8 X 4300");
        acc(2'b00, 16'h8300, 1'b0, 24'd0, "R8 X 8300");
        acc(2'b00, 16'hC300, 1'b0, 24'd0, "R8 X C300");
        acc(2'b10, 16'h4300, 1'b0, 24'd0, "R8 P 4300");
        acc(2'b10, 16'hC300, 1'b0, 24'd0, "R8 P C300");
        check(m_e[ext_index(2'b10, 16'hC300)] == 24'hABC123, "R8 model alias", m_e[ext_index(2'b10, 16'hC300)], 24'hABC123);
        acc(2'b00, 16'h0000, 1'b1, 24'h111111, "R9 write returns old");
        acc(2'b00, 16'h4000, 1'b1, 24'h222222, "R9 write returns old");
        acc(2'b00, 16'h0000, 1'b0, 24'd0, "R8 X 0000 distinct from 4000");
        acc(2'b00, 16'h4000, 1'b0, 24'd0, "R8 X 4000");
        acc(2'b10, 16'h0005, 1'b1, 24'h0A0A0A, "R9 P write returns old");
        acc(2'b10, 16'h0005, 1'b0, 24'd0, "R9 P reads new");

        // idle hold (R1)
        repeat (2) @(negedge clk);
        check(rvalid === 1'b0 && rdata === 24'h0A0A0A, "R1 idle hold", rdata, 24'h0A0A0A);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule